// File: doc/BRIEF.md
# Pager Alert Output Sequencer

This block turns a call-received event into activity on the alert outputs of a paging receiver: a low acoustic line, a high acoustic line, a tone-select line for the warble, a vibrator line and an LED line. An 8-bit write-only set-up word decides everything else. It picks the on/off source, which is either an external cadence input or one of four built-in call-type patterns. It also picks one or two acoustic lines, a pulsed or a steady vibrator, and whether a 16 Hz warble is applied. Each output group has its own enable.

The alert runs from the call strobe until a stop request arrives. It also ends after a programmable number of complete 16-step pattern passes. Pattern steps, the vibrator pulse and the warble toggle are all driven by enable ticks from a shared prescaler, so the whole block runs on the system clock. A new set-up word written during an alert is held back until the next step tick, so an output never changes part of the way through a step.

Top module: `alert_seq`

## Requirements
- R1: After reset the set-up word is all zeros and every output is low. A call received with that word in place drives `alert_on` high and leaves every alert output low.
- R2: Set-up bit 0 selects the source. With 0, the on/off state follows `cad_in`. With 1, it comes from a 16-step pattern chosen by bits 7:6. Step 0 goes first. Code 00 is 8 on then 8 off, code 01 is 4 on/4 off, code 10 is 2 on/2 off and code 11 is 1 on/1 off.
- R3: Set-up bit 1 = 0 drives only `aud_lo`. Bit 1 = 1 drives `aud_hi` together with `aud_lo`.
- R4: With bit 1 = 1 the vibrator is steady while the alert is on. With bit 1 = 0 it toggles on each `tick_vib` (a 50 Hz tick gives 25 Hz) and starts in the on phase.
- R5: Set-up bit 2 = 1 adds warble. Each `tick_wbl` toggles a phase that starts high. `led_on` follows that phase, and `tone_hi` follows it while the acoustic output is on. With bit 2 = 0, `tone_hi` stays low.
- R6: Set-up bits 3, 4 and 5 enable the acoustic lines, the vibrator and the LED respectively. A group that is disabled stays low.
- R7: A `call_stb` with no `stop_req` starts or restarts the alert, one cycle later, at step 0 with zero repetitions counted and both phases high.
- R8: `stop_req` ends the alert one cycle later, and it wins over a `call_stb` in the same cycle.
- R9: With a non-zero `rep_max`, the alert ends on the step tick that completes that many 16-step passes. A value of 0 never ends the alert.
- R10: A set-up write while idle takes effect on the next cycle. A write while active is held back and takes effect on the next `tick_step`. A write made in the same cycle as a tick takes effect at that tick.
- R11: The step index advances only on `tick_step` while active, and it wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Set-up word write strobe |
| cfg_wdata | input | 8 | Set-up word value |
| call_stb | input | 1 | Call-received strobe, starts the alert |
| stop_req | input | 1 | Stop request, ends the alert |
| cad_in | input | 1 | External cadence on/off level |
| tick_step | input | 1 | Pattern step enable (1/16 s) |
| tick_vib | input | 1 | Vibrator pulse toggle enable |
| tick_wbl | input | 1 | Warble toggle enable |
| rep_max | input | 4 | Pattern passes before auto stop, 0 = unlimited |
| aud_lo | output | 1 | Low acoustic drive |
| aud_hi | output | 1 | High acoustic drive |
| tone_hi | output | 1 | Warble tone select, 1 = upper frequency |
| vib_on | output | 1 | Vibrator drive |
| led_on | output | 1 | LED drive |
| alert_on | output | 1 | Alert sequence active |

## Verification
Directed cases come first. The all-zero word after reset separates call handling from the output enables. Enable-only words written in the middle of a step show whether a write is held back or applied at once. Pattern code 00, stepped past step 7, shows that the step index really selects the pattern bit. The cadence source with `cad_in` toggled shows that the source selection is wired correctly. Random words, ticks, calls, stops and repetition limits then mix loud and quiet levels, warble and all four pattern codes against a cycle model of the requirements. This exposes wrong phase resets, wrong priority between stop and call, and off-by-one errors at the end of a repetition.

// File: rtl/alert_pkg.sv
package alert_pkg;

    localparam int STEP_W = 4;

    // Set-up word layout, bit 7 down to bit 0
    typedef struct packed {
        logic [1:0] ctype;    // call-type pattern code
        logic       led_en;
        logic       vib_en;
        logic       aud_en;
        logic       warble;
        logic       loud;
        logic       pat_src;  // 1 = call-type pattern, 0 = cadence input
    } alert_cfg_t;

    // Code c gives runs of 2^(3-c) on steps then as many off steps
    function automatic logic pattern_bit(input logic [1:0] code, input logic [STEP_W-1:0] step);
        logic [1:0] idx;
        idx = 2'd3 - code;
        return ~step[idx];
    endfunction

endpackage

// File: rtl/alert_cfg_ctrl.sv
module alert_cfg_ctrl
    import alert_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       step_tick_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output alert_cfg_t cfg_o
);

    typedef struct packed {
        alert_cfg_t cur;
        alert_cfg_t pend;
        logic       pend_v;
    } cfg_st_t;

    cfg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (run_i) begin
            if (step_tick_i) begin
                if (wr_en_i)          s_d.cur = alert_cfg_t'(wr_data_i);
                else if (s_q.pend_v)  s_d.cur = s_q.pend;
                s_d.pend_v = 1'b0;
            end else if (wr_en_i) begin
                s_d.pend   = alert_cfg_t'(wr_data_i);
                s_d.pend_v = 1'b1;
            end
        end else begin
            if (wr_en_i)          s_d.cur = alert_cfg_t'(wr_data_i);
            else if (s_q.pend_v)  s_d.cur = s_q.pend;
            s_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_o = s_q.cur;

endmodule

// File: rtl/alert_timebase.sv
module alert_timebase
    import alert_pkg::*;
#(
    parameter int REP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              step_tick_i,
    input  logic [REP_W-1:0]  rep_max_i,
    output logic              run_o,
    output logic [STEP_W-1:0] step_o
);

    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
        logic [REP_W-1:0]  rep;
    } tb_st_t;

    tb_st_t s_d, s_q;
    logic [REP_W-1:0] rep_nx;

    always_comb begin
        s_d    = s_q;
        rep_nx = s_q.rep + 1'b1;
        if (stop_i) begin
            s_d.run = 1'b0;
        end else if (start_i) begin
            s_d.run  = 1'b1;
            s_d.step = '0;
            s_d.rep  = '0;
        end else if (s_q.run && step_tick_i) begin
            s_d.step = s_q.step + 1'b1;
            if (s_q.step == '1) begin
                s_d.rep = rep_nx;
                if (rep_max_i != '0 && rep_nx == rep_max_i) s_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_o  = s_q.run;
    assign step_o = s_q.step;

endmodule

// File: rtl/alert_mod.sv
module alert_mod (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    input  logic vib_tick_i,
    input  logic wbl_tick_i,
    output logic vib_ph_o,
    output logic wbl_ph_o
);

    typedef struct packed {
        logic vib_ph;
        logic wbl_ph;
    } ph_st_t;

    ph_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.vib_ph = 1'b1;
            s_d.wbl_ph = 1'b1;
        end else if (run_i) begin
            if (vib_tick_i) s_d.vib_ph = ~s_q.vib_ph;
            if (wbl_tick_i) s_d.wbl_ph = ~s_q.wbl_ph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vib_ph_o = s_q.vib_ph;
    assign wbl_ph_o = s_q.wbl_ph;

endmodule

// File: rtl/alert_outmux.sv
module alert_outmux
    import alert_pkg::*;
(
    input  logic              run_i,
    input  alert_cfg_t        cfg_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              cad_i,
    input  logic              vib_ph_i,
    input  logic              wbl_ph_i,
    output logic              aud_lo_o,
    output logic              aud_hi_o,
    output logic              tone_hi_o,
    output logic              vib_o,
    output logic              led_o
);

    logic src, on;

    always_comb begin
        src       = cfg_i.pat_src ? pattern_bit(cfg_i.ctype, step_i) : cad_i;
        on        = run_i & src;
        aud_lo_o  = on & cfg_i.aud_en;
        aud_hi_o  = on & cfg_i.aud_en & cfg_i.loud;
        tone_hi_o = on & cfg_i.aud_en & cfg_i.warble & wbl_ph_i;
        vib_o     = on & cfg_i.vib_en & (cfg_i.loud | vib_ph_i);
        led_o     = on & cfg_i.led_en & (~cfg_i.warble | wbl_ph_i);
    end

endmodule

// File: rtl/alert_seq.sv
module alert_seq
    import alert_pkg::*;
#(
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic             call_stb,
    input  logic             stop_req,
    input  logic             cad_in,
    input  logic             tick_step,
    input  logic             tick_vib,
    input  logic             tick_wbl,
    input  logic [REP_W-1:0] rep_max,
    output logic             aud_lo,
    output logic             aud_hi,
    output logic             tone_hi,
    output logic             vib_on,
    output logic             led_on,
    output logic             alert_on
);

    alert_cfg_t        cfg_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic              start;
    logic              vib_ph, wbl_ph;

    assign start = call_stb & ~stop_req;

    alert_cfg_ctrl u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_q),
        .step_tick_i (tick_step),
        .wr_en_i     (cfg_wr),
        .wr_data_i   (cfg_wdata),
        .cfg_o       (cfg_q)
    );

    alert_timebase #(.REP_W(REP_W)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .stop_i      (stop_req),
        .step_tick_i (tick_step),
        .rep_max_i   (rep_max),
        .run_o       (run_q),
        .step_o      (step_q)
    );

    alert_mod u_mod (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .run_i      (run_q),
        .vib_tick_i (tick_vib),
        .wbl_tick_i (tick_wbl),
        .vib_ph_o   (vib_ph),
        .wbl_ph_o   (wbl_ph)
    );

    alert_outmux u_mux (
        .run_i     (run_q),
        .cfg_i     (cfg_q),
        .step_i    (step_q),
        .cad_i     (cad_in),
        .vib_ph_i  (vib_ph),
        .wbl_ph_i  (wbl_ph),
        .aud_lo_o  (aud_lo),
        .aud_hi_o  (aud_hi),
        .tone_hi_o (tone_hi),
        .vib_o     (vib_on),
        .led_o     (led_on)
    );

    assign alert_on = run_q;

endmodule

// File: rtl/alert_seq_chk.sv
module alert_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       call_stb,
    input logic       stop_req,
    input logic       tick_step,
    input logic       aud_lo,
    input logic       aud_hi,
    input logic       tone_hi,
    input logic       vib_on,
    input logic       led_on,
    input logic       alert_on,
    input logic [7:0] cfg_q,
    input logic [3:0] step_q
);

    // R3
    hi_implies_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aud_hi |-> aud_lo);

    // R5
    tone_implies_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tone_hi |-> aud_lo);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_on |-> !(aud_lo || aud_hi || tone_hi || vib_on || led_on));

    // R7
    call_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_stb && !stop_req) |=> (alert_on && step_q == 4'd0));

    // R8
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !alert_on);

    // R10
    cfg_hold_mid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_on && !tick_step) |=> $stable(cfg_q));

    // R11
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_on && !tick_step && !call_stb) |=> $stable(step_q));

endmodule

bind alert_seq alert_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_stb  (call_stb),
    .stop_req  (stop_req),
    .tick_step (tick_step),
    .aud_lo    (aud_lo),
    .aud_hi    (aud_hi),
    .tone_hi   (tone_hi),
    .vib_on    (vib_on),
    .led_on    (led_on),
    .alert_on  (alert_on),
    .cfg_q     (cfg_q),
    .step_q    (step_q)
);

// File: tb/alert_seq_tb.sv
module alert_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       call_stb = 1'b0, stop_req = 1'b0, cad_in = 1'b0;
    logic       tick_step = 1'b0, tick_vib = 1'b0, tick_wbl = 1'b0;
    logic [3:0] rep_max = 4'd0;
    logic       aud_lo, aud_hi, tone_hi, vib_on, led_on, alert_on;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench reference state
    logic [7:0]  m_cfg, m_pend;
    logic        m_pv, m_run, m_vph, m_wph;
    logic [3:0]  m_step, m_rep;
    logic [15:0] pat [4];

    always #5 clk = ~clk;

    alert_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .call_stb(call_stb), .stop_req(stop_req), .cad_in(cad_in),
        .tick_step(tick_step), .tick_vib(tick_vib), .tick_wbl(tick_wbl),
        .rep_max(rep_max), .aud_lo(aud_lo), .aud_hi(aud_hi), .tone_hi(tone_hi),
        .vib_on(vib_on), .led_on(led_on), .alert_on(alert_on)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic old_run, start;
        old_run = m_run;
        start   = call_stb && !stop_req;
        if (old_run) begin
            if (tick_step) begin
                if (cfg_wr) m_cfg = cfg_wdata;
                else if (m_pv) m_cfg = m_pend;
                m_pv = 1'b0;
            end else if (cfg_wr) begin
                m_pend = cfg_wdata;
                m_pv   = 1'b1;
            end
        end else begin
            if (cfg_wr) m_cfg = cfg_wdata;
            else if (m_pv) m_cfg = m_pend;
            m_pv = 1'b0;
        end
        if (stop_req) m_run = 1'b0;
        else if (start) begin
            m_run = 1'b1; m_step = 4'd0; m_rep = 4'd0;
        end else if (old_run && tick_step) begin
            if (m_step == 4'd15) begin
                m_step = 4'd0;
                m_rep  = m_rep + 4'd1;
                if (rep_max != 4'd0 && m_rep == rep_max) m_run = 1'b0;
            end else m_step = m_step + 4'd1;
        end
        if (start) begin
            m_vph = 1'b1; m_wph = 1'b1;
        end else if (old_run) begin
            if (tick_vib) m_vph = ~m_vph;
            if (tick_wbl) m_wph = ~m_wph;
        end
    endtask

    task automatic compare_all();
        logic src, on, e_lo;
        src  = m_cfg[0] ? pat[m_cfg[7:6]][4'd15 - m_step] : cad_in;
        on   = m_run & src;
        e_lo = on & m_cfg[3];
        chk("R2 aud_lo", aud_lo, e_lo);
        chk("R3 aud_hi", aud_hi, e_lo & m_cfg[1]);
        chk("R5 tone_hi", tone_hi, e_lo & m_cfg[2] & m_wph);
        chk("R4 vib_on", vib_on, on & m_cfg[4] & (m_cfg[1] | m_vph));
        chk("R6 led_on", led_on, on & m_cfg[5] & (~m_cfg[2] | m_wph));
        chk("R8 alert_on", alert_on, m_run);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        cfg_wr = 1'b0; call_stb = 1'b0; stop_req = 1'b0;
        tick_step = 1'b0; tick_vib = 1'b0; tick_wbl = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL R8 watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pat[0] = 16'hFF00; pat[1] = 16'hF0F0; pat[2] = 16'hCCCC; pat[3] = 16'hAAAA;
        m_cfg = '0; m_pend = '0; m_pv = 0; m_run = 0; m_vph = 0; m_wph = 0;
        m_step = '0; m_rep = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 aud_lo", aud_lo, 1'b0);
        chk("R1 vib_on", vib_on, 1'b0);
        chk("R1 led_on", led_on, 1'b0);
        chk("R1 alert_on", alert_on, 1'b0);

        // R1 zeroed word: call runs but all outputs disabled
        cad_in = 1'b1; call_stb = 1'b1; cycle();
        chk("R7 alert_on after call", alert_on, 1'b1);
        chk("R1 aud_lo disabled", aud_lo, 1'b0);
        chk("R1 led_on disabled", led_on, 1'b0);
        stop_req = 1'b1; call_stb = 1'b1; cycle();
        chk("R8 stop beats call", alert_on, 1'b0);

        // R10 idle write immediate; code 00 pattern, loud, all enables
        wr(8'h3B); cycle();
        call_stb = 1'b1; cycle();
        chk("R7 aud_lo step0", aud_lo, 1'b1);
        chk("R7 aud_hi step0", aud_hi, 1'b1);
        chk("R7 vib_on step0", vib_on, 1'b1);
        chk("R7 led_on step0", led_on, 1'b1);
        wr(8'h03); cycle();
        chk("R10 write held mid-step aud_lo", aud_lo, 1'b1);
        chk("R10 write held mid-step led_on", led_on, 1'b1);
        tick_step = 1'b1; cycle();
        chk("R10 write applied at tick aud_lo", aud_lo, 1'b0);
        chk("R6 led disabled", led_on, 1'b0);
        wr(8'h39); tick_step = 1'b1; cycle();
        chk("R10 write on tick aud_lo", aud_lo, 1'b1);
        chk("R3 quiet aud_hi", aud_hi, 1'b0);
        chk("R4 vib pulse start", vib_on, 1'b1);
        tick_vib = 1'b1; cycle();
        chk("R4 vib pulse off", vib_on, 1'b0);
        tick_vib = 1'b1; cycle();
        chk("R4 vib pulse on", vib_on, 1'b1);
        repeat (5) cycle();
        chk("R11 no tick keeps step", aud_lo, 1'b1);
        for (int i = 0; i < 6; i++) begin tick_step = 1'b1; cycle(); end
        chk("R11 R2 step8 code00 off", aud_lo, 1'b0);

        // R5 warble
        stop_req = 1'b1; cycle();
        wr(8'h3D); cycle();
        call_stb = 1'b1; cycle();
        chk("R5 led phase high", led_on, 1'b1);
        chk("R5 tone high", tone_hi, 1'b1);
        tick_wbl = 1'b1; cycle();
        chk("R5 led phase low", led_on, 1'b0);
        chk("R5 tone low", tone_hi, 1'b0);
        chk("R5 aud_lo stays", aud_lo, 1'b1);

        // R2 cadence source
        stop_req = 1'b1; cycle();
        wr(8'h08); cycle();
        cad_in = 1'b0; call_stb = 1'b1; cycle();
        chk("R2 cadence low", aud_lo, 1'b0);
        cad_in = 1'b1; cycle();
        chk("R2 cadence high", aud_lo, 1'b1);

        // R9 repetition limit
        stop_req = 1'b1; cycle();
        wr(8'h09); rep_max = 4'd1; cycle();
        call_stb = 1'b1; cycle();
        for (int i = 0; i < 15; i++) begin tick_step = 1'b1; cycle(); end
        chk("R9 still running before last tick", alert_on, 1'b1);
        tick_step = 1'b1; cycle();
        chk("R9 ended after one pass", alert_on, 1'b0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            tick_step = ($urandom % 4) == 0;
            tick_vib  = ($urandom % 3) == 0;
            tick_wbl  = ($urandom % 5) == 0;
            if (($urandom % 8) == 0) cad_in = ~cad_in;
            if (($urandom % 40) == 0) wr(8'($urandom));
            if (!alert_on && ($urandom % 10) == 0) begin
                call_stb = 1'b1;
                rep_max  = 4'($urandom % 4);
            end else if (($urandom % 300) == 0) call_stb = 1'b1;
            if (($urandom % 200) == 0) stop_req = 1'b1;
            cycle();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule